// File: doc/BRIEF.md
# Block-Framed Stream DMA Adapter

This block lets SD/eMMC block transfers move straight between the card data path and a pair of AXI-Stream ports, so no memory-mapped DMA engine is involved. Software programs a DMA address; when that address holds the all-ones sentinel, a command start hands the transfer to this adapter. Any other address leaves the stream side idle and the transfer belongs to the memory-mapped engine elsewhere.

The direction comes from the command itself. On a card read, 32-bit words arriving from the card pass through a FIFO to the AXI-Stream master, and TLAST marks the final word of every 512-byte block (128 words at the default width). On a card write, words are pulled from the AXI-Stream slave, which carries no TLAST, for the whole multi-block length, and block edges are found purely by counting. A transfer error aborts the transfer and latches an error flag. A soft reset flushes the FIFO and both beat counters so the stream framing can be brought back into step.

Top module: `sdstream_bridge`

## Requirements
- R1: A start is taken only when `cfg_dma_addr` is all ones and `cmd_blocks` is non-zero; with any other address a start has no effect: `busy` stays low and every handshake output stays low.
- R2: The direction is captured from `cmd_dir` at the start: 0 moves card read words to the stream master, 1 moves stream slave words to the card write port; the unused path stays quiet.
- R3: On a read, the stream master emits exactly `cmd_blocks*BLK_BEATS` words in the order the card delivered them.
- R4: `m_axis_tlast` is high on a master beat exactly when that beat's index within its block (counting from 0) equals `BLK_BEATS-1`.
- R5: On a write, the stream slave accepts exactly `cmd_blocks*BLK_BEATS` words across block edges, delivers them to the card in order, and keeps `s_axis_tready` low afterwards.
- R6: While a consumer holds ready low, no word is lost and the offered master data and TLAST stay stable.
- R7: `busy` rises the cycle after an accepted start and falls with a one-cycle `done` pulse in the cycle after the final beat is handed on.
- R8: An asserted `xfer_abort` during a transfer drops `busy`, discards buffered words so a partial block ends without a TLAST beat, and sets `err`, which holds until the next accepted start or a soft reset.
- R9: `soft_rst` clears `err`, `busy`, the FIFO and both beat counters, so the next transfer frames its first block from beat 0.
- R10: A start while `busy` is high, or with `cmd_blocks` equal to 0, is ignored.
- R11: The FIFO never takes a word when full: with a blocked consumer the card-side intake stops after `FIFO_DEPTH` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of all transfer state |
| cfg_dma_addr | input | AW | Programmed DMA address; all ones selects streams |
| cmd_start | input | 1 | Command issue strobe |
| cmd_dir | input | 1 | 0 = card read, 1 = card write |
| cmd_blocks | input | BCW | Number of blocks in the transfer |
| xfer_abort | input | 1 | Transfer error (CRC fail, no response) |
| card_rd_valid | input | 1 | Card read word valid |
| card_rd_ready | output | 1 | Adapter accepts card read word |
| card_rd_data | input | DW | Card read word |
| card_wr_valid | output | 1 | Card write word valid |
| card_wr_ready | input | 1 | Card side accepts write word |
| card_wr_data | output | DW | Card write word |
| m_axis_tvalid | output | 1 | Stream master valid |
| m_axis_tready | input | 1 | Stream master ready |
| m_axis_tdata | output | DW | Stream master data |
| m_axis_tlast | output | 1 | End of 512-byte block |
| s_axis_tvalid | input | 1 | Stream slave valid |
| s_axis_tready | output | 1 | Stream slave ready |
| s_axis_tdata | input | DW | Stream slave data |
| busy | output | 1 | Stream transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Latched abort flag |

## Verification
The bench builds the adapter with `BLK_BEATS=4`, `FIFO_DEPTH=4`, `BCW=4` and a 16-bit address. Four-word blocks put several block edges, and so several TLAST beats and counter wraps, into a short run, and a FIFO only one block deep fills within a few cycles of a stalled consumer, which brings the full-FIFO intake stop and the hold of offered data within easy reach. Aborting inside a partly buffered block and then soft resetting shows that framing restarts at beat 0.

// File: rtl/sdsb_pkg.sv
package sdsb_pkg;

  typedef enum logic {
    DIR_CARD_RD = 1'b0,
    DIR_CARD_WR = 1'b1
  } sdsb_dir_e;

  // Total number of words in a transfer of the given block count.
  function automatic int unsigned sdsb_total_beats(input int unsigned blocks,
                                                   input int unsigned beats_per_blk);
    return blocks * beats_per_blk;
  endfunction

  // Index of the beat that closes a block.
  function automatic int unsigned sdsb_last_index(input int unsigned beats_per_blk);
    return beats_per_blk - 1;
  endfunction

endpackage

// File: rtl/sdsb_fifo.sv
module sdsb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n || flush)
    push |-> !full);
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n || flush)
    pop |-> !empty);

endmodule

// File: rtl/sdsb_framer.sv
module sdsb_framer #(
  parameter int BLK_BEATS = 128,
  parameter int BCW       = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load,
  input  logic [BCW-1:0] blocks,
  input  logic           step,
  output logic           active,
  output logic           last_beat,
  output logic           final_beat
);
  localparam int BW = (BLK_BEATS > 1) ? $clog2(BLK_BEATS) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(sdsb_pkg::sdsb_last_index(BLK_BEATS));

  logic [BW-1:0]  beat;
  logic [BCW-1:0] left;

  assign active     = (left != '0);
  assign last_beat  = (beat == LAST_IDX);
  assign final_beat = last_beat && (left == BCW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
      left <= '0;
    end else if (clr) begin
      beat <= '0;
      left <= '0;
    end else if (load) begin
      beat <= '0;
      left <= blocks;
    end else if (step && active) begin
      if (last_beat) begin
        beat <= '0;
        left <= left - 1'b1;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  p_beat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat <= LAST_IDX);
  p_block_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n || clr || load)
    (step && active && last_beat) |=> (beat == '0));
  p_idle_step_r5: assert property (@(posedge clk) disable iff (!rst_n || clr || load)
    (!active) |=> (!active));

endmodule

// File: rtl/sdstream_bridge.sv
module sdstream_bridge #(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int BLK_BEATS  = 128,
  parameter int FIFO_DEPTH = 128,
  parameter int BCW        = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic [AW-1:0]  cfg_dma_addr,
  input  logic           cmd_start,
  input  logic           cmd_dir,
  input  logic [BCW-1:0] cmd_blocks,
  input  logic           xfer_abort,
  input  logic           card_rd_valid,
  output logic           card_rd_ready,
  input  logic [DW-1:0]  card_rd_data,
  output logic           card_wr_valid,
  input  logic           card_wr_ready,
  output logic [DW-1:0]  card_wr_data,
  output logic           m_axis_tvalid,
  input  logic           m_axis_tready,
  output logic [DW-1:0]  m_axis_tdata,
  output logic           m_axis_tlast,
  input  logic           s_axis_tvalid,
  output logic           s_axis_tready,
  input  logic [DW-1:0]  s_axis_tdata,
  output logic           busy,
  output logic           done,
  output logic           err
);
  import sdsb_pkg::*;

  localparam logic [AW-1:0] SENTINEL = '1;

  logic      busy_q, done_q, err_q;
  sdsb_dir_e dir_q;

  // Named internal events
  logic          stream_sel, start_ok, abort_ev, finish_ev;
  logic          push, pop, flush, framer_clr;
  logic          fifo_full, fifo_empty;
  logic [DW-1:0] fifo_din, fifo_dout;
  logic          in_active, in_last, in_final;
  logic          out_active, out_last, out_final;
  logic          rd_mode, wr_mode;

  assign stream_sel = (cfg_dma_addr == SENTINEL);
  assign start_ok   = cmd_start && !busy_q && stream_sel && (cmd_blocks != '0) && !soft_rst;
  assign abort_ev   = xfer_abort && busy_q && !soft_rst;
  assign framer_clr = soft_rst || abort_ev;
  assign flush      = framer_clr || start_ok;

  assign rd_mode = busy_q && (dir_q == DIR_CARD_RD);
  assign wr_mode = busy_q && (dir_q == DIR_CARD_WR);

  // Intake side
  assign card_rd_ready = rd_mode && !fifo_full && in_active;
  assign s_axis_tready = wr_mode && !fifo_full && in_active;
  assign fifo_din      = wr_mode ? s_axis_tdata : card_rd_data;
  assign push          = (card_rd_valid && card_rd_ready) || (s_axis_tvalid && s_axis_tready);

  // Delivery side
  assign m_axis_tvalid = rd_mode && !fifo_empty;
  assign m_axis_tdata  = fifo_dout;
  assign m_axis_tlast  = out_last;
  assign card_wr_valid = wr_mode && !fifo_empty;
  assign card_wr_data  = fifo_dout;
  assign pop           = (m_axis_tvalid && m_axis_tready) || (card_wr_valid && card_wr_ready);

  assign finish_ev = pop && out_final;

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  sdsb_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .din   (fifo_din),
    .pop   (pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  sdsb_framer #(.BLK_BEATS(BLK_BEATS), .BCW(BCW)) u_in_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (framer_clr),
    .load       (start_ok),
    .blocks     (cmd_blocks),
    .step       (push),
    .active     (in_active),
    .last_beat  (in_last),
    .final_beat (in_final)
  );

  sdsb_framer #(.BLK_BEATS(BLK_BEATS), .BCW(BCW)) u_out_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (framer_clr),
    .load       (start_ok),
    .blocks     (cmd_blocks),
    .step       (pop),
    .active     (out_active),
    .last_beat  (out_last),
    .final_beat (out_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dir_q  <= DIR_CARD_RD;
    end else if (soft_rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dir_q  <= DIR_CARD_RD;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        dir_q  <= sdsb_dir_e'(cmd_dir);
      end else if (abort_ev) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else if (finish_ev) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // Guards
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !(card_rd_ready || s_axis_tready || m_axis_tvalid || card_wr_valid));
  p_one_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_axis_tvalid && card_wr_valid) && !(card_rd_ready && s_axis_tready));
  p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst || xfer_abort)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_abort_err_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    abort_ev |=> (err_q && !busy_q && !m_axis_tvalid));
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!err_q && !busy_q));
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (busy_q && !abort_ev && !finish_ev) |=> (busy_q && $stable(dir_q)));

endmodule

// File: tb/sim_sdstream_bridge.sv
module sim_sdstream_bridge;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int BB = 4;
  localparam int FD = 4;
  localparam int BCW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [AW-1:0] cfg_dma_addr = '0;
  logic cmd_start = 1'b0;
  logic cmd_dir = 1'b0;
  logic [BCW-1:0] cmd_blocks = '0;
  logic xfer_abort = 1'b0;
  logic card_rd_valid = 1'b0;
  logic card_rd_ready;
  logic [DW-1:0] card_rd_data = '0;
  logic card_wr_valid;
  logic card_wr_ready = 1'b0;
  logic [DW-1:0] card_wr_data;
  logic m_axis_tvalid;
  logic m_axis_tready = 1'b0;
  logic [DW-1:0] m_axis_tdata;
  logic m_axis_tlast;
  logic s_axis_tvalid = 1'b0;
  logic s_axis_tready;
  logic [DW-1:0] s_axis_tdata = '0;
  logic busy, done, err;

  always #10 clk = ~clk;

  sdstream_bridge #(.DW(DW), .AW(AW), .BLK_BEATS(BB), .FIFO_DEPTH(FD), .BCW(BCW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_dma_addr(cfg_dma_addr),
    .cmd_start(cmd_start), .cmd_dir(cmd_dir), .cmd_blocks(cmd_blocks),
    .xfer_abort(xfer_abort),
    .card_rd_valid(card_rd_valid), .card_rd_ready(card_rd_ready), .card_rd_data(card_rd_data),
    .card_wr_valid(card_wr_valid), .card_wr_ready(card_wr_ready), .card_wr_data(card_wr_data),
    .m_axis_tvalid(m_axis_tvalid), .m_axis_tready(m_axis_tready),
    .m_axis_tdata(m_axis_tdata), .m_axis_tlast(m_axis_tlast),
    .s_axis_tvalid(s_axis_tvalid), .s_axis_tready(s_axis_tready), .s_axis_tdata(s_axis_tdata),
    .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_err = 0;

  // Stimulus controls (written only by tasks)
  int rd_feed = 0, wr_feed = 0;
  logic [DW-1:0] rd_base = '0, wr_base = '0;
  logic wr_force = 1'b0;
  int m_mode = 1, c_mode = 1;   // 0 = hold low, 1 = high, 2 = pattern
  logic clr_mon = 1'b0;

  // Monitor state (written only by the monitor)
  int cyc = 0;
  int rd_acc = 0, wr_acc = 0, rx_n = 0, wx_n = 0, done_n = 0;
  int last_cyc = 0, done_cyc = 0;
  logic [DW-1:0] rx_d [64];
  logic          rx_l [64];
  logic [DW-1:0] wx_d [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_mon) begin
      rd_acc <= 0; wr_acc <= 0; rx_n <= 0; wx_n <= 0; done_n <= 0;
      last_cyc <= 0; done_cyc <= 0;
    end else begin
      if (card_rd_valid && card_rd_ready) rd_acc <= rd_acc + 1;
      if (s_axis_tvalid && s_axis_tready) wr_acc <= wr_acc + 1;
      if (m_axis_tvalid && m_axis_tready && rx_n < 64) begin
        rx_d[rx_n] <= m_axis_tdata; rx_l[rx_n] <= m_axis_tlast;
        rx_n <= rx_n + 1; last_cyc <= cyc;
      end
      if (card_wr_valid && card_wr_ready && wx_n < 64) begin
        wx_d[wx_n] <= card_wr_data; wx_n <= wx_n + 1; last_cyc <= cyc;
      end
      if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
    end
  end

  always @(negedge clk) begin
    card_rd_valid = (rd_acc < rd_feed);
    card_rd_data  = rd_base + DW'(rd_acc);
    s_axis_tvalid = (wr_acc < wr_feed) || wr_force;
    s_axis_tdata  = wr_base + DW'(wr_acc);
    m_axis_tready = (m_mode == 1) || (m_mode == 2 && (cyc % 3) != 0);
    card_wr_ready = (c_mode == 1) || (c_mode == 2 && (cyc % 4) != 1);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_mon();
    @(negedge clk); clr_mon = 1'b1; rd_feed = 0; wr_feed = 0; wr_force = 1'b0;
    @(negedge clk); clr_mon = 1'b0;
  endtask

  task automatic issue(input logic [AW-1:0] addr, input logic dir, input int blocks);
    @(negedge clk);
    cfg_dma_addr = addr; cmd_dir = dir; cmd_blocks = BCW'(blocks); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_n == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err, "R7 reset idle", {busy, done, err}, 0);
    check(!m_axis_tvalid && !s_axis_tready && !card_rd_ready && !card_wr_valid,
          "R1 reset quiet", m_axis_tvalid, 0);
  endtask

  task automatic t_not_stream();
    int bad = 0;
    reset_mon(); rd_feed = 4; rd_base = 32'h50;
    issue(16'h1234, 1'b0, 2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || card_rd_ready || s_axis_tready) bad++;
    end
    check(bad == 0 && rd_acc == 0, "R1 non-sentinel address ignored", rd_acc, 0);
    issue('1, 1'b0, 0);
    repeat (2) @(negedge clk);
    check(!busy && rd_acc == 0, "R10 zero block count ignored", busy, 0);
    rd_feed = 0;
  endtask

  task automatic t_read_multi();
    int bad_d = 0, bad_l = 0;
    reset_mon(); m_mode = 2; rd_base = 32'h100;
    issue('1, 1'b0, 2);
    rd_feed = sdsb_pkg::sdsb_total_beats(2, BB);
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    wait_done();
    check(rx_n == 2 * BB, "R3 read beat count", rx_n, 2 * BB);
    for (int i = 0; i < 2 * BB; i++) begin
      if (rx_d[i] != 32'h100 + i) bad_d++;
      if (rx_l[i] != ((i % BB) == BB - 1)) bad_l++;
    end
    check(bad_d == 0, "R3 read order", bad_d, 0);
    check(bad_l == 0, "R4 tlast every block end", bad_l, 0);
    check(wx_n == 0, "R2 card write idle on read", wx_n, 0);
    check(done_n == 1 && done_cyc == last_cyc + 1, "R7 done one cycle after final beat",
          done_cyc, last_cyc + 1);
    check(!busy, "R7 busy falls", busy, 0);
  endtask

  task automatic t_write_multi();
    int bad = 0;
    reset_mon(); c_mode = 2; wr_base = 32'h200;
    issue('1, 1'b1, 3);
    wr_feed = 3 * BB;
    repeat (3) @(negedge clk);
    issue('1, 1'b0, 1);  // start while busy
    wait_done();
    check(wx_n == 3 * BB && wr_acc == 3 * BB, "R5 write beat count", wx_n, 3 * BB);
    for (int i = 0; i < 3 * BB; i++) if (wx_d[i] != 32'h200 + i) bad++;
    check(bad == 0, "R5 write order across blocks", bad, 0);
    check(rx_n == 0, "R2 stream master idle on write", rx_n, 0);
    check(done_n == 1, "R10 start while busy ignored", done_n, 1);
    @(negedge clk); wr_force = 1'b1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (s_axis_tready) bad++; end
    wr_force = 1'b0;
    check(bad == 0 && wr_acc == 3 * BB, "R5 no intake past length", wr_acc, 3 * BB);
    c_mode = 1;
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] held;
    int bad = 0;
    reset_mon(); m_mode = 0; rd_base = 32'h300;
    issue('1, 1'b0, 2);
    rd_feed = 2 * BB;
    repeat (10) @(negedge clk);
    check(rd_acc == FD, "R11 intake stops when FIFO full", rd_acc, FD);
    held = m_axis_tdata;
    repeat (2) @(negedge clk);
    check(m_axis_tvalid && m_axis_tdata == held && rx_n == 0, "R6 offer held under stall",
          m_axis_tdata, held);
    m_mode = 1;
    wait_done();
    for (int i = 0; i < 2 * BB; i++) if (rx_d[i] != 32'h300 + i) bad++;
    check(rx_n == 2 * BB && bad == 0, "R6 no word lost", bad, 0);
  endtask

  task automatic t_abort_soft();
    int tl = 0;
    reset_mon(); m_mode = 0; rd_base = 32'h400;
    issue('1, 1'b0, 2);
    rd_feed = BB - 1;
    repeat (8) @(negedge clk);
    xfer_abort = 1'b1; @(negedge clk); xfer_abort = 1'b0;
    m_mode = 1;
    repeat (5) @(negedge clk);
    check(err && !busy, "R8 abort latches error", err, 1);
    check(rx_n == 0 && !m_axis_tvalid, "R8 partial block dropped, no tlast", rx_n, 0);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    check(!err && !busy, "R9 soft reset clears error", err, 0);
    reset_mon(); rd_base = 32'h500;
    issue('1, 1'b0, 1);
    rd_feed = BB;
    wait_done();
    for (int i = 0; i < BB; i++) if (rx_l[i] != (i == BB - 1)) tl++;
    check(rx_n == BB && tl == 0 && rx_d[0] == 32'h500, "R9 framing restarts at beat 0", tl, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_not_stream();
    t_read_multi();
    t_write_multi();
    t_backpressure();
    t_abort_soft();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule